// File: doc/BRIEF.md
# Floating-Point Add Special-Operand Resolver

This block sits one stage ahead of an extended-precision floating-point adder. It accepts a source and a destination operand. Each operand has a sign bit, an exponent field and a mantissa. The mantissa carries an explicit integer bit at its top. The block sorts each operand into one of five classes: zero, infinity, in-range number, quiet NaN or signaling NaN. From the pair of classes, the rounding mode and the signaling-NaN trap enable, it picks one of three outcomes.

The three outcomes are:
- hand the operands on to the ordinary add datapath;
- deliver a finished special result at once;
- cancel the destination write and request an exception.

Two status bits travel with every result: operation error and signaling NaN.

Classification and the decision are combinational. The outcome, the result fields and the two status bits are then captured in one register stage. The registers load whenever `in_valid` is high and hold their value otherwise.

Top module: `fpa_special_resolver`

## Requirements

- R1: After a cycle with `in_valid` high, the outcome appears at the next rising edge, and `out_valid` is high for that one cycle. The `out_kind` encoding is 00 for pass to the add path, 01 for a special result and 10 for a suppressed write with an exception request.
- R2: Two zeros of the same sign give out_kind 01 and a zero of that sign, with exponent 0 and mantissa 0. A zero has exponent 0 and mantissa 0.
- R3: Two zeros of opposite sign give out_kind 01 and a zero, with exponent 0 and mantissa 0. The sign of that zero is 1 only when `rnd_mode` is 10 (toward minus infinity). It is 0 for 00 (nearest), 01 (toward zero) and 11 (toward plus infinity).
- R4: If both operands are in range, or one is zero and the other in range, the result is out_kind 00. The result fields read 0 and both status bits read 0.
- R5: An infinity paired with a zero or an in-range number gives out_kind 01 and that infinity's fields unchanged. Two infinities of the same sign give that infinity. An infinity has the all-ones exponent and an all-zero fraction, where the fraction is the mantissa below its integer bit.
- R6: Two infinities of opposite sign give out_kind 01, `operr` = 1, and the default NaN. The default NaN has sign 0, an all-ones exponent and an all-ones mantissa.
- R7: A NaN has the all-ones exponent and a nonzero fraction. It is quiet when mantissa bit MAN_W-2 is 1. If exactly one operand is a NaN, the result is that NaN. If both operands are NaNs, the result is the destination NaN. In both cases out_kind is 01.
- R8: `snan_flag` is 1 whenever either operand is a signaling NaN, whatever the trap enable is.
- R9: If `snan_en` = 1 and either operand is a signaling NaN, out_kind is 10. The result fields read 0 and `operr` reads 0.
- R10: If `snan_en` = 0, a signaling NaN operand is made quiet by setting mantissa bit MAN_W-2 and is then treated under R7. A NaN result always has bit MAN_W-2 set.
- R11: While `in_valid` is low, all outputs except `out_valid` hold their last values. During reset every output reads 0.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| src_sign | input | 1 | Source sign |
| src_exp | input | EXP_W | Source exponent |
| src_man | input | MAN_W | Source mantissa, explicit integer bit at the top |
| dst_sign | input | 1 | Destination sign |
| dst_exp | input | EXP_W | Destination exponent |
| dst_man | input | MAN_W | Destination mantissa |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 to zero, 10 to minus inf, 11 to plus inf |
| snan_en | input | 1 | Signaling-NaN trap enable |
| out_valid | output | 1 | Result registers loaded in the previous cycle |
| out_kind | output | 2 | Outcome: 00 pass, 01 special, 10 suppress |
| res_sign | output | 1 | Special result sign |
| res_exp | output | EXP_W | Special result exponent |
| res_man | output | MAN_W | Special result mantissa |
| operr | output | 1 | Operation error status |
| snan_flag | output | 1 | Signaling-NaN status |

## Verification

The bench builds the block with its default widths: a 15-bit exponent and a 64-bit mantissa. With those widths the quiet bit falls at mantissa bit 62, next to the explicit integer bit. Random operands drawn evenly from the five classes exercise every class pairing under every rounding mode and both trap settings. Random integer bits on infinities and NaNs confirm that only the fraction decides the class, and random fraction bits on signaling NaNs confirm that quieting changes nothing but the quiet bit.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_INF  = 3'd1,
    CLS_NUM  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } opclass_e;

  typedef enum logic [1:0] {
    OUT_PASS     = 2'b00,
    OUT_SPECIAL  = 2'b01,
    OUT_SUPPRESS = 2'b10
  } outcome_e;

  localparam logic [1:0] RM_NEAR  = 2'b00;
  localparam logic [1:0] RM_ZERO  = 2'b01;
  localparam logic [1:0] RM_MINUS = 2'b10;
  localparam logic [1:0] RM_PLUS  = 2'b11;

  localparam int NUM_OPS = 2;
  localparam int OP_SRC  = 0;
  localparam int OP_DST  = 1;

endpackage

// File: rtl/fpa_classify.sv
module fpa_classify
  import fpa_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output opclass_e         cls_o
);
  localparam int FRAC_W = MAN_W - 1;

  logic exp_max;
  logic exp_min;
  logic frac_nz;
  logic quiet_bit;
  logic int_bit;

  assign exp_max   = &exp_i;
  assign exp_min   = ~|exp_i;
  assign frac_nz   = |man_i[FRAC_W-1:0];
  assign quiet_bit = man_i[FRAC_W-1];
  assign int_bit   = man_i[MAN_W-1];

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)       cls_o = CLS_INF;
      else if (quiet_bit) cls_o = CLS_QNAN;
      else                cls_o = CLS_SNAN;
    end else if (exp_min && !frac_nz && !int_bit) begin
      cls_o = CLS_ZERO;
    end else begin
      cls_o = CLS_NUM;
    end
  end

endmodule

// File: rtl/fpa_decide.sv
module fpa_decide
  import fpa_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  opclass_e         src_cls_i,
  input  logic             src_sign_i,
  input  logic [EXP_W-1:0] src_exp_i,
  input  logic [MAN_W-1:0] src_man_i,
  input  opclass_e         dst_cls_i,
  input  logic             dst_sign_i,
  input  logic [EXP_W-1:0] dst_exp_i,
  input  logic [MAN_W-1:0] dst_man_i,
  input  logic [1:0]       rnd_mode_i,
  input  logic             snan_en_i,
  output outcome_e         kind_o,
  output logic             r_sign_o,
  output logic [EXP_W-1:0] r_exp_o,
  output logic [MAN_W-1:0] r_man_o,
  output logic             operr_o,
  output logic             snan_o
);
  localparam int QBIT = MAN_W - 2;

  function automatic logic [MAN_W-1:0] quieten(input logic [MAN_W-1:0] m);
    logic [MAN_W-1:0] q;
    q       = m;
    q[QBIT] = 1'b1;
    return q;
  endfunction

  function automatic logic zero_sum_sign(input logic sa, input logic sb,
                                         input logic [1:0] rm);
    if (sa == sb) return sa;
    return (rm == RM_MINUS);
  endfunction

  // Internal events, brought out as named wires
  logic src_nan, dst_nan, any_nan, any_snan;
  logic trap_hit, inf_clash, zero_pair;

  assign src_nan   = (src_cls_i == CLS_QNAN) || (src_cls_i == CLS_SNAN);
  assign dst_nan   = (dst_cls_i == CLS_QNAN) || (dst_cls_i == CLS_SNAN);
  assign any_nan   = src_nan || dst_nan;
  assign any_snan  = (src_cls_i == CLS_SNAN) || (dst_cls_i == CLS_SNAN);
  assign trap_hit  = any_snan && snan_en_i;
  assign inf_clash = (src_cls_i == CLS_INF) && (dst_cls_i == CLS_INF) &&
                     (src_sign_i != dst_sign_i);
  assign zero_pair = (src_cls_i == CLS_ZERO) && (dst_cls_i == CLS_ZERO);

  assign snan_o = any_snan;

  always_comb begin
    kind_o   = OUT_PASS;
    r_sign_o = 1'b0;
    r_exp_o  = '0;
    r_man_o  = '0;
    operr_o  = 1'b0;
    if (trap_hit) begin
      kind_o = OUT_SUPPRESS;
    end else if (any_nan) begin
      kind_o = OUT_SPECIAL;
      if (dst_nan) begin
        r_sign_o = dst_sign_i;
        r_exp_o  = dst_exp_i;
        r_man_o  = quieten(dst_man_i);
      end else begin
        r_sign_o = src_sign_i;
        r_exp_o  = src_exp_i;
        r_man_o  = quieten(src_man_i);
      end
    end else if (inf_clash) begin
      kind_o  = OUT_SPECIAL;
      r_exp_o = '1;
      r_man_o = '1;
      operr_o = 1'b1;
    end else if (dst_cls_i == CLS_INF) begin
      kind_o   = OUT_SPECIAL;
      r_sign_o = dst_sign_i;
      r_exp_o  = dst_exp_i;
      r_man_o  = dst_man_i;
    end else if (src_cls_i == CLS_INF) begin
      kind_o   = OUT_SPECIAL;
      r_sign_o = src_sign_i;
      r_exp_o  = src_exp_i;
      r_man_o  = src_man_i;
    end else if (zero_pair) begin
      kind_o   = OUT_SPECIAL;
      r_sign_o = zero_sum_sign(src_sign_i, dst_sign_i, rnd_mode_i);
    end
  end

  // R7 a NaN input never leaves the add path open
  always_comb begin
    if (any_nan) begin
      nan_not_pass_chk: assert (kind_o != OUT_PASS);
    end
  end

endmodule

// File: rtl/fpa_special_resolver.sv
module fpa_special_resolver
  import fpa_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             src_sign,
  input  logic [EXP_W-1:0] src_exp,
  input  logic [MAN_W-1:0] src_man,
  input  logic             dst_sign,
  input  logic [EXP_W-1:0] dst_exp,
  input  logic [MAN_W-1:0] dst_man,
  input  logic [1:0]       rnd_mode,
  input  logic             snan_en,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [MAN_W-1:0] res_man,
  output logic             operr,
  output logic             snan_flag
);
  localparam int QBIT = MAN_W - 2;

  logic [NUM_OPS-1:0][EXP_W-1:0] op_exp;
  logic [NUM_OPS-1:0][MAN_W-1:0] op_man;
  opclass_e                      op_cls [NUM_OPS];

  assign op_exp[OP_SRC] = src_exp;
  assign op_exp[OP_DST] = dst_exp;
  assign op_man[OP_SRC] = src_man;
  assign op_man[OP_DST] = dst_man;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fpa_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .exp_i (op_exp[g]),
      .man_i (op_man[g]),
      .cls_o (op_cls[g])
    );
  end

  outcome_e         nx_kind;
  logic             nx_sign;
  logic [EXP_W-1:0] nx_exp;
  logic [MAN_W-1:0] nx_man;
  logic             nx_operr;
  logic             nx_snan;

  fpa_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_decide (
    .src_cls_i  (op_cls[OP_SRC]),
    .src_sign_i (src_sign),
    .src_exp_i  (src_exp),
    .src_man_i  (src_man),
    .dst_cls_i  (op_cls[OP_DST]),
    .dst_sign_i (dst_sign),
    .dst_exp_i  (dst_exp),
    .dst_man_i  (dst_man),
    .rnd_mode_i (rnd_mode),
    .snan_en_i  (snan_en),
    .kind_o     (nx_kind),
    .r_sign_o   (nx_sign),
    .r_exp_o    (nx_exp),
    .r_man_o    (nx_man),
    .operr_o    (nx_operr),
    .snan_o     (nx_snan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= OUT_PASS;
      res_sign  <= 1'b0;
      res_exp   <= '0;
      res_man   <= '0;
      operr     <= 1'b0;
      snan_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind  <= nx_kind;
        res_sign  <= nx_sign;
        res_exp   <= nx_exp;
        res_man   <= nx_man;
        operr     <= nx_operr;
        snan_flag <= nx_snan;
      end
    end
  end

  // R6
  operr_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    operr |-> (out_kind == OUT_SPECIAL) && !res_sign && (&res_exp) && (&res_man));

  // R9
  suppress_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == OUT_SUPPRESS) |-> snan_flag && !operr && (res_exp == '0) && (res_man == '0));

  // R10
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_kind == OUT_SPECIAL) && (&res_exp) && (|res_man[QBIT:0])) |-> res_man[QBIT]);

  // R4
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == OUT_PASS) |-> !operr && !res_sign && (res_exp == '0) && (res_man == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_kind) && $stable(res_man) && $stable(res_exp) &&
                  $stable(res_sign) && $stable(operr) && $stable(snan_flag));

endmodule

// File: tb/fpa_special_resolver_tb.sv
module fpa_special_resolver_tb;
  localparam int EW = 15;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          src_sign = 1'b0, dst_sign = 1'b0;
  logic [EW-1:0] src_exp = '0, dst_exp = '0;
  logic [MW-1:0] src_man = '0, dst_man = '0;
  logic [1:0]    rnd_mode = 2'b00;
  logic          snan_en = 1'b0;
  logic          out_valid, res_sign, operr, snan_flag;
  logic [1:0]    out_kind;
  logic [EW-1:0] res_exp;
  logic [MW-1:0] res_man;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpa_special_resolver #(.EXP_W(EW), .MAN_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_sign(src_sign), .src_exp(src_exp), .src_man(src_man),
    .dst_sign(dst_sign), .dst_exp(dst_exp), .dst_man(dst_man),
    .rnd_mode(rnd_mode), .snan_en(snan_en),
    .out_valid(out_valid), .out_kind(out_kind), .res_sign(res_sign),
    .res_exp(res_exp), .res_man(res_man), .operr(operr), .snan_flag(snan_flag)
  );

  typedef struct packed {
    logic          v;
    logic [1:0]    k;
    logic          s;
    logic [EW-1:0] e;
    logic [MW-1:0] m;
    logic          oe;
    logic          sn;
  } obs_t;

  // 0 zero, 1 inf, 2 number, 3 qnan, 4 snan
  function automatic int kind_of(input logic [EW-1:0] e, input logic [MW-1:0] m);
    if (e == {EW{1'b1}}) begin
      if (m[MW-2:0] == 0) return 1;
      return m[MW-2] ? 3 : 4;
    end
    if (e == 0 && m == 0) return 0;
    return 2;
  endfunction

  function automatic obs_t model(input logic ss, input logic [EW-1:0] se, input logic [MW-1:0] sm,
                                 input logic ds, input logic [EW-1:0] de, input logic [MW-1:0] dm,
                                 input logic [1:0] rm, input logic en, output string tag);
    obs_t o;
    int a, b;
    o = '0;
    o.v = 1'b1;
    a = kind_of(se, sm);
    b = kind_of(de, dm);
    o.sn = (a == 4) || (b == 4);
    if (o.sn && en) begin
      o.k = 2'b10; tag = "R9";
    end else if (a >= 3 || b >= 3) begin
      o.k = 2'b01;
      tag = o.sn ? "R10" : "R7";
      if (b >= 3) begin o.s = ds; o.e = de; o.m = dm | (64'd1 << (MW-2)); end
      else        begin o.s = ss; o.e = se; o.m = sm | (64'd1 << (MW-2)); end
    end else if (a == 1 && b == 1 && ss != ds) begin
      o.k = 2'b01; o.oe = 1'b1; o.e = '1; o.m = '1; tag = "R6";
    end else if (a == 1 || b == 1) begin
      o.k = 2'b01; tag = "R5";
      if (b == 1) begin o.s = ds; o.e = de; o.m = dm; end
      else        begin o.s = ss; o.e = se; o.m = sm; end
    end else if (a == 0 && b == 0) begin
      o.k = 2'b01;
      if (ss == ds) begin o.s = ss; tag = "R2"; end
      else begin o.s = (rm == 2'b10); tag = "R3"; end
    end else begin
      tag = "R4";
    end
    return o;
  endfunction

  function automatic obs_t sample();
    return '{out_valid, out_kind, res_sign, res_exp, res_man, operr, snan_flag};
  endfunction

  task automatic check(input obs_t got, input obs_t exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic ss, input logic [EW-1:0] se, input logic [MW-1:0] sm,
                       input logic ds, input logic [EW-1:0] de, input logic [MW-1:0] dm,
                       input logic [1:0] rm, input logic en);
    obs_t exp;
    string tag;
    @(negedge clk);
    src_sign = ss; src_exp = se; src_man = sm;
    dst_sign = ds; dst_exp = de; dst_man = dm;
    rnd_mode = rm; snan_en = en; in_valid = 1'b1;
    exp = model(ss, se, sm, ds, de, dm, rm, en, tag);
    @(negedge clk);
    in_valid = 1'b0;
    check(sample(), exp, tag);
  endtask

  function automatic logic [MW-1:0] rnd_man();
    return {$urandom(), $urandom()};
  endfunction

  task automatic gen(input int c, output logic [EW-1:0] e, output logic [MW-1:0] m);
    m = rnd_man();
    case (c)
      0: begin e = '0; m = '0; end
      1: begin e = '1; m[MW-2:0] = '0; end
      2: begin e = EW'($urandom_range(0, (1 << EW) - 2)); m[MW-1] = 1'b1; end
      3: begin e = '1; m[MW-2] = 1'b1; end
      default: begin e = '1; m[MW-2] = 1'b0; m[0] = 1'b1; end
    endcase
  endtask

  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [MW-1:0] INFM = 64'h8000_0000_0000_0000;
  localparam logic [MW-1:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [MW-1:0] QN1  = 64'hC000_0000_0000_1234;
  localparam logic [MW-1:0] QN2  = 64'hC000_0000_0000_5678;
  localparam logic [MW-1:0] SN1  = 64'h8000_0000_0000_0055;

  initial begin
    obs_t held;
    obs_t zero_o;
    string tag;
    void'($urandom(32'h5EED_1234));
    zero_o = '0;
    repeat (3) @(negedge clk);
    check(sample(), zero_o, "R11 reset");
    rst_n = 1'b1;

    // R2 same-sign zeros
    apply(1, '0, '0, 1, '0, '0, 2'b00, 0);
    apply(0, '0, '0, 0, '0, '0, 2'b10, 0);
    // R3 opposite zeros, each rounding mode
    for (int r = 0; r < 4; r++) apply(0, '0, '0, 1, '0, '0, 2'(r), 0);
    // R4 pass cases
    apply(0, 15'h3FFF, ONE, 1, '0, '0, 2'b00, 0);
    apply(1, 15'h4001, ONE, 0, 15'h3FFE, ONE, 2'b01, 1);
    // R5 infinity with finite and same-sign pair
    apply(1, EMAX, INFM, 0, 15'h1234, ONE, 2'b00, 0);
    apply(0, '0, '0, 1, EMAX, INFM, 2'b11, 0);
    apply(1, EMAX, INFM, 1, EMAX, '0, 2'b00, 0);
    // R6 opposite infinities
    apply(0, EMAX, INFM, 1, EMAX, INFM, 2'b10, 0);
    // R7 quiet NaN single and pair
    apply(1, EMAX, QN1, 0, EMAX, INFM, 2'b00, 0);
    apply(0, EMAX, QN1, 1, EMAX, QN2, 2'b00, 0);
    // R8 R9 trap on signaling NaN
    apply(0, EMAX, SN1, 0, 15'h10, ONE, 2'b00, 1);
    // R10 quieting without trap, dst priority with mixed NaNs
    apply(0, EMAX, QN1, 1, EMAX, SN1, 2'b00, 0);
    apply(1, EMAX, SN1, 0, EMAX, ONE, 2'b01, 0);

    // R11 hold while in_valid low
    held = sample();
    @(negedge clk);
    src_exp = EMAX; src_man = SN1; snan_en = 1'b1;
    @(negedge clk);
    held.v = 1'b0;
    check(sample(), held, "R11 hold");
    // R1 out_valid falls after idle cycle
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 out_valid got=%0b expected=0", out_valid);
    end

    for (int i = 0; i < 600; i++) begin
      logic [EW-1:0] e1, e2;
      logic [MW-1:0] m1, m2;
      gen($urandom_range(0, 4), e1, m1);
      gen($urandom_range(0, 4), e2, m2);
      apply($urandom_range(0, 1), e1, m1, $urandom_range(0, 1), e2, m2,
            2'($urandom_range(0, 3)), $urandom_range(0, 1));
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule